// File: doc/BRIEF.md
# System Control Register Bank

This block is a bank of 32-bit control registers that sits behind a simple synchronous register bus. Software addresses it with a 12-bit byte offset, which gives a 4 KiB window. Behind the window are 512 word registers. Writes store their data. Reads return the stored word one cycle later. A few identification registers come out of reset with fixed values, and every other register resets to zero.

Two behaviours go beyond plain storage. First, a write to the command offset 0xF00 is decoded. The value 1 or 2 raises a one-cycle system reset request, and the value 3 raises a one-cycle power-off request. The written value is stored in every case. Second, reads at three status offsets (0x100, 0x108, 0x10C) return the stored word with bits 29 and 28 forced to one. The forced bits are never written into storage.

The window holds twice as many word positions as there are registers. The register index is therefore the word offset modulo 512, and the upper half of the window mirrors the lower half. The command and status offsets are still decoded on the full offset.

Top module: `sysctl_bank`

## Requirements
- R1: After reset, the words at byte offsets 0x100, 0x104, 0x108 and 0x10C hold 0x05F20121, 0x00000002, 0x05F30121 and 0x05F40121.
- R2: After reset, every other register reads as zero. Read data is zero and both request outputs are low.
- R3: A write (valid=1, we=1) stores the write data in the addressed register. A read (valid=1, we=0) returns that register on the read data port in the cycle after the read is accepted. A later write to the same register fully replaces the earlier value.
- R4: Offset bits [1:0] are ignored, so offsets 0x023 and 0x020 address the same register.
- R5: The register index is the word offset (bits [11:2]) modulo 512, so byte offset 0x800+X addresses the same register as X.
- R6: A read whose full word offset equals 0x100, 0x108 or 0x10C returns the stored value with bits 29 and 28 set. The stored value is unchanged, so a read through the mirror offset (0x900, 0x908, 0x90C) shows the raw word.
- R7: A write of 1 or 2 to offset 0xF00 drives the reset request high for exactly the one cycle after the write is accepted.
- R8: A write of 3 to offset 0xF00 drives the power-off request high for exactly the one cycle after the write is accepted.
- R9: No other access raises a request. This covers other values at 0xF00, reads of 0xF00, writes to the mirror offset 0x700, and writes elsewhere. The two requests are never high together.
- R10: A write to 0xF00 stores its value like any other write, and that value reads back at 0xF00 and at 0x700.
- R11: Read data changes only in the cycle after an accepted read. Writes and idle cycles leave it unchanged, and reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| sys_reset_req | output | 1 | One-cycle system reset request |
| sys_off_req | output | 1 | One-cycle power-off request |

## Verification
Directed accesses cover the following cases:
- The identification reset values, read through both the status offsets and their mirrors, which separates the forced read bits from the stored data.
- Overwrites and unaligned offsets, which show full replacement and the ignored low bits.
- Command writes of every value from 0 to 4, plus all-ones, which show that only the values 1, 2 and 3 act.
- Writes to the storage alias of the command offset, which show that decode uses the full offset and not the register index.

A long random sequence mixes writes, reads and command-offset writes with small values. It is checked against a bench model of storage and requests, and catches any mismatch in aliasing, storage or pulse timing.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int NUM_WORDS = 512;
    localparam int WADDR_W   = ADDR_W - 2;
    localparam int IDX_W     = $clog2(NUM_WORDS);

    localparam logic [WADDR_W-1:0] CMD_WOFF  = 10'h3C0;
    localparam logic [WADDR_W-1:0] STAT0_WOFF = 10'h040;
    localparam logic [WADDR_W-1:0] STAT2_WOFF = 10'h042;
    localparam logic [WADDR_W-1:0] STAT3_WOFF = 10'h043;
    localparam logic [DATA_W-1:0]  FORCE_MASK = 32'h3000_0000;

    localparam int ID_BASE  = 'h40;
    localparam int ID_COUNT = 4;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_RESET = 2'd1,
        CMD_OFF   = 2'd2
    } cmd_e;

    typedef struct packed {
        logic               valid;
        logic               we;
        logic [WADDR_W-1:0] woff;
        logic [DATA_W-1:0]  wdata;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        case (idx)
            ID_BASE + 0: reset_value = 32'h05F2_0121;
            ID_BASE + 1: reset_value = 32'h0000_0002;
            ID_BASE + 2: reset_value = 32'h05F3_0121;
            ID_BASE + 3: reset_value = 32'h05F4_0121;
            default:     reset_value = '0;
        endcase
    endfunction

    function automatic cmd_e decode_cmd(input logic [DATA_W-1:0] d);
        case (d)
            32'd1, 32'd2: decode_cmd = CMD_RESET;
            32'd3:        decode_cmd = CMD_OFF;
            default:      decode_cmd = CMD_NONE;
        endcase
    endfunction

    function automatic logic is_forced(input logic [WADDR_W-1:0] w);
        is_forced = (w == STAT0_WOFF) || (w == STAT2_WOFF) || (w == STAT3_WOFF);
    endfunction

endpackage

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int WORDS = NUM_WORDS,
    parameter int DW    = DATA_W,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_word
);

    logic [DW-1:0] words [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                words[i] <= DW'(reset_value(i));
            end
        end else if (wr_en) begin
            words[wr_idx] <= wr_data;
        end
    end

    assign rd_word = words[rd_idx];

    // R1: the identification words hold their load values as reset is released
    for (genvar g = 0; g < ID_COUNT; g++) begin : g_id_chk
        a_r1_id_reset : assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> (words[ID_BASE + g] == DW'(reset_value(ID_BASE + g))));
    end

    // R2: a register that is not an identification word starts at zero
    a_r2_zero_reset : assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (words[0] == '0 && words[WORDS-1] == '0));

endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
    import sysctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     reset_req,
    output logic     off_req
);

    logic wr_cmd;
    cmd_e code;

    assign wr_cmd = req.valid && req.we && (req.woff == CMD_WOFF);
    assign code   = decode_cmd(req.wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            reset_req <= 1'b0;
            off_req   <= 1'b0;
        end else begin
            reset_req <= wr_cmd && (code == CMD_RESET);
            off_req   <= wr_cmd && (code == CMD_OFF);
        end
    end

    // R7: the values 1 and 2 at the command offset give a reset pulse
    a_r7_reset_pulse : assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.we && req.woff == CMD_WOFF &&
         (req.wdata == 32'd1 || req.wdata == 32'd2)) |=> reset_req);

    // R8: the value 3 at the command offset gives a power-off pulse
    a_r8_off_pulse : assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.we && req.woff == CMD_WOFF && req.wdata == 32'd3) |=> off_req);

    // R9: no request without a write to the command offset in the cycle before
    a_r9_no_spurious : assert property (@(posedge clk) disable iff (rst)
        (reset_req || off_req) |-> $past(req.valid && req.we && req.woff == CMD_WOFF));

    // R9: the two requests are mutually exclusive
    a_r9_exclusive : assert property (@(posedge clk) disable iff (rst)
        !(reset_req && off_req));

endmodule

// File: rtl/sysctl_rdpath.sv
module sysctl_rdpath
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [DATA_W-1:0] raw_word,
    output logic [DATA_W-1:0] rdata
);

    logic              rd_hit;
    logic [DATA_W-1:0] overlay;

    assign rd_hit  = req.valid && !req.we;
    assign overlay = is_forced(req.woff) ? FORCE_MASK : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_hit) begin
            rdata <= raw_word | overlay;
        end
    end

    // R6: a read at a status offset always returns bits 29:28 set
    a_r6_forced_bits : assert property (@(posedge clk) disable iff (rst)
        (req.valid && !req.we && (req.woff == STAT0_WOFF || req.woff == STAT2_WOFF ||
                                  req.woff == STAT3_WOFF)) |=> (rdata[29:28] == 2'b11));

    // R11: read data holds whenever no read was accepted
    a_r11_hold : assert property (@(posedge clk) disable iff (rst)
        !(req.valid && !req.we) |=> $stable(rdata));

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_reset_req,
    output logic              sys_off_req
);

    bus_req_t          req;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] raw_word;
    logic              addr_lsb_unused;

    assign req.valid = bus_valid;
    assign req.we    = bus_we;
    assign req.woff  = bus_addr[ADDR_W-1:2];
    assign req.wdata = bus_wdata;

    assign addr_lsb_unused = ^bus_addr[1:0];
    assign idx             = req.woff[IDX_W-1:0];

    sysctl_store #(
        .WORDS (NUM_WORDS),
        .DW    (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (req.valid && req.we),
        .wr_idx  (idx),
        .wr_data (req.wdata),
        .rd_idx  (idx),
        .rd_word (raw_word)
    );

    sysctl_cmd u_cmd (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .reset_req (sys_reset_req),
        .off_req   (sys_off_req)
    );

    sysctl_rdpath u_rdpath (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .raw_word (raw_word),
        .rdata    (bus_rdata)
    );

endmodule

// File: tb/sysctl_bank_tb.sv
module sysctl_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_reset_req;
    logic        sys_off_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] model [512];
    logic [31:0] last_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_bank u_dut (
        .clk           (clk),
        .rst           (rst),
        .bus_valid     (bus_valid),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .sys_reset_req (sys_reset_req),
        .sys_off_req   (sys_off_req)
    );

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [31:0] v;
        v = model[a[10:2]];
        if (a[11:2] == 10'h040 || a[11:2] == 10'h042 || a[11:2] == 10'h043)
            v = v | 32'h3000_0000;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input string req);
        bit er, eo;
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
        model[a[10:2]] = d;
        er = (a[11:2] == 10'h3C0) && (d == 32'd1 || d == 32'd2);
        eo = (a[11:2] == 10'h3C0) && (d == 32'd3);
        chk(sys_reset_req == er, {req, " reset_req"}, 32'(sys_reset_req), 32'(er));
        chk(sys_off_req == eo, {req, " off_req"}, 32'(sys_off_req), 32'(eo));
    endtask

    task automatic bus_read(input logic [11:0] a, input string req);
        logic [31:0] e;
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        e = exp_read(a);
        last_rd = e;
        chk(bus_rdata == e, req, bus_rdata, e);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=%08h expected=%08h", 32'(WATCHDOG), 32'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 512; i++) model[i] = '0;
        model['h40] = 32'h05F2_0121;
        model['h41] = 32'h0000_0002;
        model['h42] = 32'h05F3_0121;
        model['h43] = 32'h05F4_0121;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(bus_rdata == '0, "R2 rdata after reset", bus_rdata, '0);
        chk(!sys_reset_req && !sys_off_req, "R2 requests after reset",
            {30'b0, sys_reset_req, sys_off_req}, '0);

        // R1: identification words, via status offsets and mirrors
        bus_read(12'h100, "R1 id word 0x100");
        bus_read(12'h104, "R1 id word 0x104");
        bus_read(12'h108, "R1 id word 0x108");
        bus_read(12'h10C, "R1 id word 0x10C");
        bus_read(12'h900, "R1 id word raw via mirror 0x900");
        bus_read(12'h90C, "R1 id word raw via mirror 0x90C");

        // R2: other registers are zero
        bus_read(12'h000, "R2 zero 0x000");
        bus_read(12'h7FC, "R2 zero 0x7FC");
        bus_read(12'h110, "R2 zero 0x110");

        // R3: store, read back and overwrite
        bus_write(12'h020, 32'hA5A5_1234, "R3 write");
        bus_read(12'h020, "R3 readback");
        bus_write(12'h020, 32'h0F0F_C3C3, "R3 overwrite");
        bus_read(12'h020, "R3 overwrite readback");

        // R4: offset bits [1:0] ignored
        bus_write(12'h033, 32'hDEAD_BEEF, "R4 unaligned write");
        bus_read(12'h030, "R4 aligned read");
        bus_read(12'h032, "R4 unaligned read");

        // R5: upper window mirrors lower
        bus_write(12'h804, 32'h1357_9BDF, "R5 mirror write");
        bus_read(12'h004, "R5 lower read");

        // R6: forced bits are not stored
        bus_write(12'h108, 32'h0000_0000, "R6 clear status word");
        bus_read(12'h108, "R6 forced read 0x108");
        bus_read(12'h908, "R6 raw mirror 0x908");
        bus_write(12'h104, 32'h0000_0000, "R6 clear 0x104");
        bus_read(12'h104, "R6 unforced 0x104");
        bus_write(12'h10C, 32'hCFFF_FFFF, "R6 write 0x10C");
        bus_read(12'h10C, "R6 forced read 0x10C");
        bus_read(12'h90C, "R6 raw mirror 0x90C");

        // R7, R8: command pulses last one cycle
        bus_write(12'hF00, 32'd1, "R7 command 1");
        @(negedge clk);
        chk(!sys_reset_req, "R7 pulse width", 32'(sys_reset_req), '0);
        bus_write(12'hF00, 32'd2, "R7 command 2");
        bus_write(12'hF00, 32'd3, "R8 command 3");
        @(negedge clk);
        chk(!sys_off_req, "R8 pulse width", 32'(sys_off_req), '0);

        // R9: nothing else raises a request
        bus_write(12'hF00, 32'd0, "R9 command 0");
        bus_write(12'hF00, 32'd4, "R9 command 4");
        bus_write(12'hF00, 32'hFFFF_FFFF, "R9 command all ones");
        bus_write(12'hF04, 32'd1, "R9 value 1 at 0xF04");
        bus_write(12'h700, 32'd3, "R9 value 3 at storage alias 0x700");
        bus_read(12'hF00, "R9 read of command offset");
        chk(!sys_reset_req && !sys_off_req, "R9 read raises nothing",
            {30'b0, sys_reset_req, sys_off_req}, '0);

        // R10: command writes are stored
        bus_write(12'hF00, 32'h0000_0002, "R10 command write");
        bus_read(12'hF00, "R10 readback 0xF00");
        bus_read(12'h700, "R10 readback 0x700");

        // R11: read data holds through writes and idle cycles
        bus_read(12'h020, "R11 reference read");
        bus_write(12'h024, 32'h7777_8888, "R11 intervening write");
        repeat (3) @(negedge clk);
        chk(bus_rdata == last_rd, "R11 rdata held", bus_rdata, last_rd);

        // Random mix, R3 R5 R6 R7 R8 R9
        for (int n = 0; n < 400; n++) begin
            int unsigned kind;
            logic [11:0] a;
            logic [31:0] d;
            kind = $urandom % 5;
            a = 12'($urandom);
            d = $urandom;
            case (kind)
                0, 1: bus_write(a, d, "R3 random write");
                2:    bus_write(12'hF00, 32'($urandom % 5), "R7 R8 R9 random command");
                3:    bus_read(a, "R5 random read");
                default: begin
                    case ($urandom % 3)
                        0: a = 12'h100;
                        1: a = 12'h108;
                        default: a = 12'h10C;
                    endcase
                    bus_read(a, "R6 random status read");
                end
            endcase
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule